// File: doc/BRIEF.md
# Multi-bank selectable clock divider

The block divides one shared reference clock into four banks of two outputs each. Each bank takes a 3-bit code that picks its ratio from the set 1, 2, 3, 4, 5, 6 and 8. Every output has its own enable bit, and a global enable can switch off all eight at once. Each output is a registered true/complement pair. A disabled pair rests with the true side low and the complement side high.

The design runs on a sampling clock, `clk_i`, that is twice the reference frequency. One reference cycle is therefore two `clk_i` cycles, and divide-by-n gives a period of 2n `clk_i` cycles. An active-low divider reset holds all banks still. When reset is released, every enabled output goes high on the same edge. From then on, every rising edge of a divided output falls on a rising edge of a divide-by-1 output.

Ratio changes and enable changes are deferred to safe points, so no output ever shows a shortened pulse.

Top module: `clkdiv_fanout`

## Requirements
- R1: Bank b takes its code from `div_code_i[3b+2:3b]`, with bank A at b=0. The codes map as 000→1, 001→2, 010→3, 011→4, 100→5 and 101→6. Ratio n gives an output period of 2n `clk_i` cycles.
- R2: The reserved code 110 behaves exactly like 111, which is divide-by-8.
- R3: For every ratio, the output is high for n `clk_i` cycles and then low for n cycles.
- R4: While `rst_ni` is low, every `clk_p_o` bit is 0. At start-up all outputs stay low until they are enabled. On the first rising `clk_i` edge after release, every output whose enables are set goes high.
- R5: Every rising edge of any output falls on an edge that is an odd number of `clk_i` edges after reset release. These are the rising edges of a divide-by-1 output.
- R6: While `oe_all_i` is low, an output that is low stays low, whatever its bit in `oe_i` says. An output that is high finishes its high phase and then stays low.
- R7: While `oe_all_i` is high, output index b*2+k (bank b, member k) follows `oe_i[b*2+k]`.
- R8: An enable change applies only on an edge where that bank's divided clock was low. No high pulse is ever cut short or started part-way through.
- R9: A new code for a bank applies only at that bank's next rising edge. The period in progress completes at the old ratio.
- R10: `clk_n_o` is at all times the bitwise inverse of `clk_p_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock, twice the reference frequency |
| rst_ni | input | 1 | Asynchronous active-low divider reset |
| oe_all_i | input | 1 | Global output enable, overrides the per-output enables |
| div_code_i | input | 12 | Per-bank ratio codes, 3 bits per bank |
| oe_i | input | 8 | Per-output enable bits |
| clk_p_o | output | 8 | True side of the divided outputs |
| clk_n_o | output | 8 | Complement side of the divided outputs |

## Verification
A wrong phase count or a wrong latched ratio shows up at the ports within one output period, which is at most 16 cycles. It appears as a wrong high or low run length, or as a rising edge on the wrong parity relative to reset release. A bad enable register shows up as a missing pulse, or as a pulse that is shorter than n cycles, at the next rising edge of its bank. The reference model compares all sixteen output bits on every cycle, so any divergence is caught on the cycle it first appears.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CODE_W    = 3;
  localparam int MAX_RATIO = 8;
  localparam int RAT_W     = $clog2(MAX_RATIO + 1);
  localparam int PH_W      = $clog2(2 * MAX_RATIO);

  // reserved 3'b110 runs at the slowest ratio so the clock never stalls
  function automatic logic [RAT_W-1:0] ratio_of(input logic [CODE_W-1:0] code);
    case (code)
      3'b000:  ratio_of = RAT_W'(1);
      3'b001:  ratio_of = RAT_W'(2);
      3'b010:  ratio_of = RAT_W'(3);
      3'b011:  ratio_of = RAT_W'(4);
      3'b100:  ratio_of = RAT_W'(5);
      3'b101:  ratio_of = RAT_W'(6);
      default: ratio_of = RAT_W'(MAX_RATIO);
    endcase
  endfunction
endpackage

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic              raw_nxt_o,
  output logic              raw_q_o
);
  logic [PH_W-1:0]  ph_q;
  logic [RAT_W-1:0] rat_q, rat_cur;
  logic [PH_W:0]    ph_last;

  // ratio only reloads at phase 0, i.e. on a rising edge
  always_comb begin
    rat_cur   = (ph_q == '0) ? ratio_of(code_i) : rat_q;
    ph_last   = {(PH_W+1-RAT_W)'(0), rat_cur} + {(PH_W+1-RAT_W)'(0), rat_cur} - (PH_W+1)'(1);
    raw_nxt_o = (PH_W+1)'(ph_q) < (PH_W+1)'(rat_cur);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= '0;
      rat_q   <= RAT_W'(1);
      raw_q_o <= 1'b0;
    end else begin
      rat_q   <= rat_cur;
      raw_q_o <= raw_nxt_o;
      ph_q    <= ((PH_W+1)'(ph_q) == ph_last) ? '0 : ph_q + PH_W'(1);
    end
  end
endmodule

// File: rtl/clkdiv_out_gate.sv
module clkdiv_out_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_q_i,
  input  logic raw_nxt_i,
  input  logic req_i,
  output logic out_o
);
  logic en_q, en_nxt;

  // enable may only move while the divided clock is low
  assign en_nxt = raw_q_i ? en_q : req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      out_o <= 1'b0;
    end else begin
      en_q  <= en_nxt;
      out_o <= raw_nxt_i & en_nxt;
    end
  end
endmodule

// File: rtl/clkdiv_fanout.sv
module clkdiv_fanout
  import clkdiv_pkg::*;
#(
  parameter int NUM_BANKS     = 4,
  parameter int OUTS_PER_BANK = 2,
  localparam int NUM_OUTS     = NUM_BANKS * OUTS_PER_BANK
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        oe_all_i,
  input  logic [NUM_BANKS*CODE_W-1:0] div_code_i,
  input  logic [NUM_OUTS-1:0]         oe_i,
  output logic [NUM_OUTS-1:0]         clk_p_o,
  output logic [NUM_OUTS-1:0]         clk_n_o
);
  logic [NUM_BANKS-1:0] raw_nxt, raw_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    clkdiv_bank u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .code_i   (div_code_i[b*CODE_W +: CODE_W]),
      .raw_nxt_o(raw_nxt[b]),
      .raw_q_o  (raw_q[b])
    );
    for (genvar k = 0; k < OUTS_PER_BANK; k++) begin : g_out
      clkdiv_out_gate u_gate (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .raw_q_i  (raw_q[b]),
        .raw_nxt_i(raw_nxt[b]),
        .req_i    (oe_all_i & oe_i[b*OUTS_PER_BANK+k]),
        .out_o    (clk_p_o[b*OUTS_PER_BANK+k])
      );
    end
  end

  assign clk_n_o = ~clk_p_o;
endmodule

// File: rtl/clkdiv_fanout_chk.sv
module clkdiv_fanout_chk #(
  parameter int NUM_OUTS  = 8,
  parameter int MAX_RATIO = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                oe_all_i,
  input logic [NUM_OUTS-1:0] oe_i,
  input logic [NUM_OUTS-1:0] clk_p_o
);
  logic par_q;
  logic [4:0] hi_cnt [NUM_OUTS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) par_q <= 1'b0;
    else         par_q <= ~par_q;
  end

  AST_RESET_QUIET: assert property (@(posedge clk_i) !rst_ni |-> clk_p_o == '0); // R4

  for (genvar i = 0; i < NUM_OUTS; i++) begin : g_chk
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                hi_cnt[i] <= '0;
      else if (!clk_p_o[i])       hi_cnt[i] <= '0;
      else if (hi_cnt[i] != 5'h1f) hi_cnt[i] <= hi_cnt[i] + 5'd1;
    end

    AST_DISABLED_HOLDS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(oe_all_i && oe_i[i]) && !clk_p_o[i] |=> !clk_p_o[i]); // R6

    AST_RISE_ON_PARITY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(clk_p_o[i]) |-> par_q); // R5

    AST_HIGH_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hi_cnt[i] <= 5'(MAX_RATIO)); // R2
  end
endmodule

bind clkdiv_fanout clkdiv_fanout_chk #(
  .NUM_OUTS (NUM_OUTS),
  .MAX_RATIO(clkdiv_pkg::MAX_RATIO)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .oe_all_i(oe_all_i),
  .oe_i    (oe_i),
  .clk_p_o (clk_p_o)
);

// File: tb/sim_clkdiv_fanout.sv
`timescale 1ns/1ps
module sim_clkdiv_fanout;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        oe_all = 1'b0;
  logic [11:0] code = '0;
  logic [7:0]  oe = '0;
  logic [7:0]  clk_p, clk_n;
  int checks = 0, errors = 0;
  bit done = 0, mdl_on = 0;

  always #4 clk = ~clk;

  clkdiv_fanout u0 (
    .clk_i(clk), .rst_ni(rst_n), .oe_all_i(oe_all), .div_code_i(code),
    .oe_i(oe), .clk_p_o(clk_p), .clk_n_o(clk_n)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int ratio(input logic [2:0] c);
    if (c >= 3'd6) return 8;
    return int'(c) + 1;
  endfunction

  // behavioural reference
  int pos [4], nact [4];
  bit rawq [4];
  bit en [8];
  logic [7:0] m_out;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 4; b++) begin pos[b] = 0; nact[b] = 1; rawq[b] = 0; end
      for (int i = 0; i < 8; i++) en[i] = 0;
      m_out = '0;
    end else begin
      for (int b = 0; b < 4; b++) begin
        int n;
        bit hi;
        n  = (pos[b] == 0) ? ratio(code[b*3 +: 3]) : nact[b];
        hi = pos[b] < n;
        for (int k = 0; k < 2; k++) begin
          if (!rawq[b]) en[b*2+k] = oe_all & oe[b*2+k];
          m_out[b*2+k] = hi & en[b*2+k];
        end
        nact[b] = n;
        rawq[b] = hi;
        pos[b]  = (pos[b] == 2*n - 1) ? 0 : pos[b] + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (mdl_on && rst_n) begin
      chk(clk_p == m_out, "R1 R3 R7 R8 R9 model", clk_p, m_out);
      chk(clk_n == ~clk_p, "R10 complement", clk_n, ~clk_p);
    end
  end

  task automatic measure(input int idx, output int hi, output int lo);
    while (clk_p[idx])  @(negedge clk);
    while (!clk_p[idx]) @(negedge clk);
    hi = 0; lo = 0;
    while (clk_p[idx])  begin hi++; @(negedge clk); end
    while (!clk_p[idx]) begin lo++; @(negedge clk); end
  endtask

  task automatic sync_rise(input int idx);
    while (clk_p[idx])  @(negedge clk);
    while (!clk_p[idx]) @(negedge clk);
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int hi, lo, cnt;
    logic [7:0] prev;
    repeat (3) @(negedge clk);
    chk(clk_p == 8'h00, "R4 reset low", clk_p, 0);
    chk(clk_n == 8'hff, "R10 reset complement", clk_n, 255);

    code = {3'b011, 3'b010, 3'b001, 3'b000};
    oe_all = 1'b1; oe = 8'hff;
    @(negedge clk);
    chk(clk_p == 8'h00, "R4 held in reset", clk_p, 0);
    rst_n = 1'b1; mdl_on = 1;
    @(negedge clk);
    chk(clk_p == 8'hff, "R4 all rise together", clk_p, 255);

    // R5: every rise coincides with a divide-by-1 rise on bank A
    cnt = 0; prev = clk_p;
    for (int c = 0; c < 48; c++) begin
      @(negedge clk);
      if (((clk_p & ~prev) != 0) && !(clk_p[0] && !prev[0])) cnt++;
      prev = clk_p;
    end
    chk(cnt == 0, "R5 misaligned rises", cnt, 0);

    for (int b = 0; b < 4; b++) begin
      measure(b*2, hi, lo);
      chk(hi == b+1 && lo == b+1, "R1 R3 ratio 1-4", hi*100+lo, (b+1)*101);
    end

    code = {3'b111, 3'b110, 3'b101, 3'b100};
    repeat (20) @(negedge clk);
    measure(0, hi, lo); chk(hi == 5 && lo == 5, "R1 R3 ratio 5", hi*100+lo, 505);
    measure(2, hi, lo); chk(hi == 6 && lo == 6, "R1 R3 ratio 6", hi*100+lo, 606);
    measure(4, hi, lo); chk(hi == 8 && lo == 8, "R2 reserved code", hi*100+lo, 808);
    measure(6, hi, lo); chk(hi == 8 && lo == 8, "R1 ratio 8", hi*100+lo, 808);

    // R9: change bank D to divide-by-1 just after a rise
    sync_rise(6);
    code[11:9] = 3'b000;
    cnt = 0;
    while (clk_p[6]) begin cnt++; @(negedge clk); end
    chk(cnt == 8, "R9 old high phase kept", cnt, 8);
    cnt = 0;
    while (!clk_p[6]) begin cnt++; @(negedge clk); end
    chk(cnt == 8, "R9 old low phase kept", cnt, 8);
    measure(6, hi, lo);
    chk(hi == 1 && lo == 1, "R9 new ratio applied", hi*100+lo, 101);

    // R6: global disable
    code[11:9] = 3'b111;
    oe_all = 1'b0;
    repeat (20) @(negedge clk);
    cnt = 0;
    for (int c = 0; c < 24; c++) begin
      if (clk_p != 0) cnt++;
      @(negedge clk);
    end
    chk(cnt == 0, "R6 global disable", cnt, 0);
    oe_all = 1'b1;
    repeat (20) @(negedge clk);

    // R8: disable D0 just after its rise, high phase must complete
    sync_rise(6);
    oe[6] = 1'b0;
    cnt = 0;
    while (clk_p[6]) begin cnt++; @(negedge clk); end
    chk(cnt == 8, "R8 disable waits for low", cnt, 8);
    cnt = 0;
    for (int c = 0; c < 32; c++) begin
      if (clk_p[6]) cnt++;
      @(negedge clk);
    end
    chk(cnt == 0, "R7 disabled output static", cnt, 0);
    sync_rise(7);
    oe[6] = 1'b1;
    @(negedge clk);
    chk(clk_p[6] == 1'b0, "R8 no partial pulse on enable", clk_p[6], 0);
    sync_rise(7);
    chk(clk_p[6] == 1'b1, "R8 enable at next rise", clk_p[6], 1);

    // R7: per-output map
    oe = 8'h55;
    repeat (20) @(negedge clk);
    cnt = 0; hi = 0;
    for (int c = 0; c < 40; c++) begin
      if ((clk_p & 8'haa) != 0) cnt++;
      if ((clk_p & 8'h55) != 0) hi++;
      @(negedge clk);
    end
    chk(cnt == 0, "R7 disabled members low", cnt, 0);
    chk(hi > 0, "R7 enabled members toggle", hi, 1);

    mdl_on = 0;
    done = 1;
    summary();
    $finish;
  end
endmodule